// File: doc/BRIEF.md
# Interrupt Enable, Pending and Delegation Register File

This block keeps the three interrupt control registers of a core that runs at machine, supervisor and virtual-supervisor level. These are the enable word, the pending word and the delegation word. It also presents narrower views of those same words to supervisor and hypervisor software. Every access carries a view selector, write data and a per-bit write mask. The block returns the value the view held before the access, combinationally in the same cycle. It updates the backing registers at the next clock edge, changing only bits that are both legal for that view and selected by the mask.

Interrupt bits sit at fixed positions. Software bits are at 1, 2 and 3, timer bits at 5, 6 and 7, and external bits at 9, 10 and 11, each group ordered supervisor, virtual-supervisor, machine. Bits 0 and 8 are the user software and user external bits; they matter only to the supervisor pending view.

Pending bits can be owned by hardware. A bit whose claim input is high copies its hardware source on every clock and ignores software. When the virtualization input is high, the supervisor views move the virtual-supervisor bits down one place into the supervisor slots. When the hypervisor option is built in, the three virtual-supervisor delegation bits are forced on by every delegation write.

Top module: `irq_csr_file`

## Requirements
- R1: Synchronous active-low reset clears the enable, pending and delegation registers to zero.
- R2: Selector 0 (machine enable) reads the full enable word. A write changes only the mask-selected bits among 1,2,3,5,6,7,9,10,11 (legal mask 0xEEE); all other bits keep their value.
- R3: Selector 2 (delegation) changes only the mask-selected bits among 1,2,5,6,9,10 (0x666). When HAS_HYP is 1, any access to it with a nonzero mask leaves bits 2, 6 and 10 set. No other selector changes the delegation word.
- R4: Selector 1 (machine pending) returns the old pending word. A write changes only bits that are in the mask, are delegable (0x666) and are not claimed. Machine-level pending bits never change through software.
- R5: A pending bit whose claim input is high takes the value of its hardware input at each clock edge, one cycle later, whatever software writes.
- R6: Selector 3 (supervisor enable) with virtualization off reads enable AND delegation. A write updates only the mask-selected bits among 1,5,9 (0x222).
- R7: Selector 3 with virtualization on reads (enable AND delegation AND 0x444) shifted right by one. A write shifts data and mask left by one and updates only bits 2,6,10.
- R8: Selector 4 (supervisor pending) with virtualization off reads pending AND delegation. A write may change only bits in mask AND 0x103 AND 0x666 AND delegation, and only if unclaimed. With virtualization on, it reads (pending AND delegation AND 0x444) shifted right by one, and a write may change only bit 2: mask bit 1, delegation bit 2 set, bit 2 unclaimed, value taken from data bit 1.
- R9: Selector 5 (hypervisor enable) reads and writes only bits 2,6,10 of the enable word. Selector 6 (hypervisor pending) reads pending AND 0x444 and may write only unclaimed bits among 2,6,10.
- R10: Selector 7 is unmapped: it reads zero and changes nothing. The read port is zero whenever no request is valid.
- R11: An access completes in one cycle: the read port gives the pre-access value in the request cycle, and the updated registers appear on the outputs after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_sel | input | 3 | View selector, codes 0 to 7 |
| req_wdata | input | XLEN | Write data in the selected view's bit layout |
| req_wmask | input | XLEN | Per-bit write mask in the view's layout; zero means read only |
| virt_on | input | 1 | Virtualization active |
| hw_pend | input | XLEN | Hardware pending sources |
| hw_claim | input | XLEN | Per-bit hardware ownership of pending bits |
| rd_data | output | XLEN | Old value of the selected view |
| irq_enable | output | XLEN | Enable register |
| irq_pending | output | XLEN | Pending register |
| irq_deleg | output | XLEN | Delegation register |

## Verification
The hardest situation to reach is a software write to the pending word that collides with hardware ownership. The write must target a bit that is delegated, not yet claimed in one view and claimed in another, all while virtualization moves the legal slot. Random stimulus drives sparse claim and hardware-pending patterns with random virtualization and masks on every access, so such collisions happen often. Directed accesses first set up delegation, then write a claimed bit and confirm it tracks hardware rather than the write data.

// File: rtl/irq_csr_pkg.sv
// Package: view selector codes and the fixed legal-bit masks (12-bit form,
// zero-extended by users). Assumes the standard interrupt bit layout.
package irq_csr_pkg;

    typedef enum logic [2:0] {
        VIEW_M_EN   = 3'd0,
        VIEW_M_PEND = 3'd1,
        VIEW_DELEG  = 3'd2,
        VIEW_S_EN   = 3'd3,
        VIEW_S_PEND = 3'd4,
        VIEW_H_EN   = 3'd5,
        VIEW_H_PEND = 3'd6,
        VIEW_NONE   = 3'd7
    } irq_view_e;

    localparam int LOW_BITS = 12;

    localparam logic [LOW_BITS-1:0] LVL_SUP    = 12'h222; // bits 1,5,9
    localparam logic [LOW_BITS-1:0] LVL_VSUP   = 12'h444; // bits 2,6,10
    localparam logic [LOW_BITS-1:0] LVL_MACH   = 12'h888; // bits 3,7,11
    localparam logic [LOW_BITS-1:0] ANY_LEVEL  = LVL_SUP | LVL_VSUP | LVL_MACH;
    localparam logic [LOW_BITS-1:0] DELEGABLE  = LVL_SUP | LVL_VSUP;
    localparam logic [LOW_BITS-1:0] SUP_PEND_W = 12'h103; // bits 0,1,8

endpackage

// File: rtl/irq_view_decode.sv
// View decoder: maps one access to a read value and per-register bit write
// enables. Purely combinational; assumes XLEN >= 12 and that at most one
// backing register is written per access.
module irq_view_decode
    import irq_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            valid,
    input  logic [2:0]      sel,
    input  logic            virt,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] wmask,
    input  logic [XLEN-1:0] cur_en,
    input  logic [XLEN-1:0] cur_pend,
    input  logic [XLEN-1:0] cur_deleg,
    input  logic [XLEN-1:0] claim,
    output logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] en_we,
    output logic [XLEN-1:0] pend_we,
    output logic [XLEN-1:0] deleg_we,
    output logic [XLEN-1:0] wval,
    output logic            deleg_touch
);
    localparam int PADW = XLEN - LOW_BITS;
    localparam logic [XLEN-1:0] M_SUP   = {{PADW{1'b0}}, LVL_SUP};
    localparam logic [XLEN-1:0] M_VSUP  = {{PADW{1'b0}}, LVL_VSUP};
    localparam logic [XLEN-1:0] M_ANY   = {{PADW{1'b0}}, ANY_LEVEL};
    localparam logic [XLEN-1:0] M_DLG   = {{PADW{1'b0}}, DELEGABLE};
    localparam logic [XLEN-1:0] M_SPW   = {{PADW{1'b0}}, SUP_PEND_W};

    logic [XLEN-1:0] sw_free;
    irq_view_e       view;

    assign sw_free = ~claim;
    assign view    = irq_view_e'(sel);

    // Select the read view and the legal write bits for the addressed view.
    always_comb begin
        rdata       = '0;
        en_we       = '0;
        pend_we     = '0;
        deleg_we    = '0;
        wval        = wdata;
        deleg_touch = 1'b0;
        if (valid) begin
            case (view)
                VIEW_M_EN: begin
                    rdata = cur_en;
                    en_we = wmask & M_ANY;
                end
                VIEW_M_PEND: begin
                    rdata   = cur_pend;
                    pend_we = wmask & M_DLG & sw_free;
                end
                VIEW_DELEG: begin
                    rdata       = cur_deleg;
                    deleg_we    = wmask & M_DLG;
                    deleg_touch = |wmask;
                end
                VIEW_S_EN: begin
                    if (virt) begin
                        rdata = (cur_en & cur_deleg & M_VSUP) >> 1;
                        en_we = (wmask << 1) & M_VSUP;
                        wval  = wdata << 1;
                    end else begin
                        rdata = cur_en & cur_deleg;
                        en_we = wmask & M_SUP;
                    end
                end
                VIEW_S_PEND: begin
                    if (virt) begin
                        rdata   = (cur_pend & cur_deleg & M_VSUP) >> 1;
                        pend_we = ((wmask & M_SPW) << 1) & M_VSUP & cur_deleg & sw_free;
                        wval    = wdata << 1;
                    end else begin
                        rdata   = cur_pend & cur_deleg;
                        pend_we = wmask & M_SPW & M_DLG & cur_deleg & sw_free;
                    end
                end
                VIEW_H_EN: begin
                    rdata = cur_en & M_VSUP;
                    en_we = wmask & M_VSUP;
                end
                VIEW_H_PEND: begin
                    rdata   = cur_pend & M_VSUP;
                    pend_we = wmask & M_VSUP & sw_free;
                end
                default: begin
                    rdata = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
// Bit-masked register: updates only enabled bits, and optionally ORs a fixed
// pattern in on a touch. Assumes FORCE_BITS is a constant.
module irq_mask_reg #(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] FORCE_BITS = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] we,
    input  logic [XLEN-1:0] wval,
    input  logic            touch,
    output logic [XLEN-1:0] q
);
    logic [XLEN-1:0] force_v;

    generate
        if (FORCE_BITS != '0) begin : g_force
            assign force_v = touch ? FORCE_BITS : '0;
        end else begin : g_noforce
            assign force_v = '0;
        end
    endgenerate

    // Merge enabled write bits into the held value, then apply forcing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q & ~we) | (wval & we) | force_v;
        end
    end

endmodule

// File: rtl/irq_pend_reg.sv
// Pending register: claimed bits copy their hardware source every cycle,
// unclaimed bits take software writes. Assumes write enables already
// exclude claimed bits, but claim still has priority here.
module irq_pend_reg #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] we,
    input  logic [XLEN-1:0] wval,
    input  logic [XLEN-1:0] hw_src,
    input  logic [XLEN-1:0] hw_own,
    output logic [XLEN-1:0] q
);
    logic [XLEN-1:0] sw_next;

    assign sw_next = (q & ~we) | (wval & we);

    // Per bit, hardware ownership wins over the software path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (sw_next & ~hw_own) | (hw_src & hw_own);
        end
    end

endmodule

// File: rtl/irq_csr_file.sv
// Top: interrupt enable/pending/delegation register file with machine,
// supervisor and hypervisor views. Single-cycle access, old value returned
// combinationally. Assumes XLEN >= 12.
module irq_csr_file
    import irq_csr_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit HAS_HYP = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_sel,
    input  logic [XLEN-1:0] req_wdata,
    input  logic [XLEN-1:0] req_wmask,
    input  logic            virt_on,
    input  logic [XLEN-1:0] hw_pend,
    input  logic [XLEN-1:0] hw_claim,
    output logic [XLEN-1:0] rd_data,
    output logic [XLEN-1:0] irq_enable,
    output logic [XLEN-1:0] irq_pending,
    output logic [XLEN-1:0] irq_deleg
);
    localparam logic [XLEN-1:0] DLG_FORCE =
        HAS_HYP ? {{(XLEN-LOW_BITS){1'b0}}, LVL_VSUP} : '0;

    logic [XLEN-1:0] en_we, pend_we, deleg_we, wval;
    logic            deleg_touch;

    irq_view_decode #(.XLEN(XLEN)) u_dec (
        .valid      (req_valid),
        .sel        (req_sel),
        .virt       (virt_on),
        .wdata      (req_wdata),
        .wmask      (req_wmask),
        .cur_en     (irq_enable),
        .cur_pend   (irq_pending),
        .cur_deleg  (irq_deleg),
        .claim      (hw_claim),
        .rdata      (rd_data),
        .en_we      (en_we),
        .pend_we    (pend_we),
        .deleg_we   (deleg_we),
        .wval       (wval),
        .deleg_touch(deleg_touch)
    );

    irq_mask_reg #(.XLEN(XLEN), .FORCE_BITS('0)) u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (en_we),
        .wval (wval),
        .touch(1'b0),
        .q    (irq_enable)
    );

    irq_mask_reg #(.XLEN(XLEN), .FORCE_BITS(DLG_FORCE)) u_deleg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (deleg_we),
        .wval (wval),
        .touch(deleg_touch),
        .q    (irq_deleg)
    );

    irq_pend_reg #(.XLEN(XLEN)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pend_we),
        .wval  (wval),
        .hw_src(hw_pend),
        .hw_own(hw_claim),
        .q     (irq_pending)
    );

endmodule

// File: rtl/irq_csr_checker.sv
// Checker: temporal properties of the register file at its ports.
// Bound to every instance of irq_csr_file.
module irq_csr_checker
    import irq_csr_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit HAS_HYP = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_sel,
    input logic [XLEN-1:0] req_wmask,
    input logic [XLEN-1:0] hw_pend,
    input logic [XLEN-1:0] hw_claim,
    input logic [XLEN-1:0] rd_data,
    input logic [XLEN-1:0] irq_enable,
    input logic [XLEN-1:0] irq_pending,
    input logic [XLEN-1:0] irq_deleg
);
    localparam logic [XLEN-1:0] C_VS   = {{(XLEN-LOW_BITS){1'b0}}, LVL_VSUP};
    localparam logic [XLEN-1:0] C_MACH = {{(XLEN-LOW_BITS){1'b0}}, LVL_MACH};

    logic en_view;
    assign en_view = req_valid && (req_sel == 3'd0 || req_sel == 3'd3 || req_sel == 3'd5);

    assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_view |=> $stable(irq_enable));

    assert_deleg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_sel == 3'd2) |=> $stable(irq_deleg));

    assert_deleg_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_HYP && req_valid && req_sel == 3'd2 && req_wmask != '0)
        |=> ((irq_deleg & C_VS) == C_VS));

    assert_mach_pend_sw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (((irq_pending ^ $past(irq_pending)) & C_MACH & ~$past(hw_claim)) == '0));

    assert_claim_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_claim != '0) |=> ((irq_pending & $past(hw_claim)) == ($past(hw_pend) & $past(hw_claim))));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_sel == 3'd7) |-> (rd_data == '0));

endmodule

bind irq_csr_file irq_csr_checker #(.XLEN(XLEN), .HAS_HYP(HAS_HYP)) u_irq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_sel    (req_sel),
    .req_wmask  (req_wmask),
    .hw_pend    (hw_pend),
    .hw_claim   (hw_claim),
    .rd_data    (rd_data),
    .irq_enable (irq_enable),
    .irq_pending(irq_pending),
    .irq_deleg  (irq_deleg)
);

// File: tb/tb_irq_csr_file.sv
// Bench: directed corner cases plus seeded random accesses, checked against a
// model written from the requirements.
module tb_irq_csr_file;
    localparam int XLEN = 32;
    localparam logic [31:0] K_ALL  = 32'hEEE;
    localparam logic [31:0] K_DLG  = 32'h666;
    localparam logic [31:0] K_SUP  = 32'h222;
    localparam logic [31:0] K_VS   = 32'h444;
    localparam logic [31:0] K_SPW  = 32'h103;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_sel = 3'd0;
    logic [XLEN-1:0] req_wdata = '0, req_wmask = '0;
    logic            virt_on = 1'b0;
    logic [XLEN-1:0] hw_pend = '0, hw_claim = '0;
    logic [XLEN-1:0] rd_data, irq_enable, irq_pending, irq_deleg;

    logic [31:0] m_en = '0, m_pend = '0, m_dlg = '0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_csr_file #(.XLEN(XLEN), .HAS_HYP(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_wdata(req_wdata), .req_wmask(req_wmask), .virt_on(virt_on),
        .hw_pend(hw_pend), .hw_claim(hw_claim), .rd_data(rd_data),
        .irq_enable(irq_enable), .irq_pending(irq_pending), .irq_deleg(irq_deleg)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string view_tag(input logic [2:0] s, input logic v);
        case (s)
            3'd0: return "R2";
            3'd1: return "R4";
            3'd2: return "R3";
            3'd3: return v ? "R7" : "R6";
            3'd4: return "R8";
            3'd5, 3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    // One access: drive at negedge, check old value, then registers after edge.
    task automatic access(input logic vld, input logic [2:0] s, input logic v,
                          input logic [31:0] d, input logic [31:0] m,
                          input logic [31:0] hp, input logic [31:0] hc);
        logic [31:0] e_rd, w_en, w_pd, w_dl, dd;
        logic frc;
        @(negedge clk);
        req_valid = vld; req_sel = s; virt_on = v; req_wdata = d; req_wmask = m;
        hw_pend = hp; hw_claim = hc;
        e_rd = '0; w_en = '0; w_pd = '0; w_dl = '0; dd = d; frc = 1'b0;
        if (vld) begin
            case (s)
                3'd0: begin e_rd = m_en; w_en = m & K_ALL; end
                3'd1: begin e_rd = m_pend; w_pd = m & K_DLG & ~hc; end
                3'd2: begin e_rd = m_dlg; w_dl = m & K_DLG; frc = (m != 0); end
                3'd3: if (v) begin
                          e_rd = (m_en & m_dlg & K_VS) >> 1; w_en = (m << 1) & K_VS; dd = d << 1;
                      end else begin
                          e_rd = m_en & m_dlg; w_en = m & K_SUP;
                      end
                3'd4: if (v) begin
                          e_rd = (m_pend & m_dlg & K_VS) >> 1;
                          w_pd = ((m & K_SPW) << 1) & K_VS & m_dlg & ~hc; dd = d << 1;
                      end else begin
                          e_rd = m_pend & m_dlg; w_pd = m & K_SPW & K_DLG & m_dlg & ~hc;
                      end
                3'd5: begin e_rd = m_en & K_VS; w_en = m & K_VS; end
                3'd6: begin e_rd = m_pend & K_VS; w_pd = m & K_VS & ~hc; end
                default: e_rd = '0;
            endcase
        end
        #1;
        check({vld ? view_tag(s, v) : "R10", " read old value (R11)"}, rd_data, e_rd);
        @(posedge clk);
        m_en   = (m_en & ~w_en) | (dd & w_en);
        m_dlg  = (m_dlg & ~w_dl) | (dd & w_dl) | (frc ? K_VS : 32'h0);
        m_pend = (((m_pend & ~w_pd) | (dd & w_pd)) & ~hc) | (hp & hc);
        #1;
        check({view_tag(s, v), " enable after edge (R11)"}, irq_enable, m_en);
        check({view_tag(s, v), " delegation after edge (R11)"}, irq_deleg, m_dlg);
        check({(hc != 0) ? "R5" : view_tag(s, v), " pending after edge (R11)"}, irq_pending, m_pend);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 enable at reset", irq_enable, 32'h0);
        check("R1 pending at reset", irq_pending, 32'h0);
        check("R1 delegation at reset", irq_deleg, 32'h0);
        rst_n = 1'b1;

        // R10: idle and unmapped selector
        access(1'b0, 3'd0, 1'b0, '1, '1, '0, '0);
        access(1'b1, 3'd7, 1'b0, '1, '1, '0, '0);
        // R3: delegation with a mask that misses the VS bits still forces them
        access(1'b1, 3'd2, 1'b0, 32'h222, 32'h002, '0, '0);
        access(1'b1, 3'd2, 1'b0, '1, '1, '0, '0);
        // R2: full-width write to machine enable keeps illegal bits zero
        access(1'b1, 3'd0, 1'b0, '1, '1, '0, '0);
        // R6 and R7: supervisor enable in both virtualization states
        access(1'b1, 3'd3, 1'b0, 32'h0, 32'h020, '0, '0);
        access(1'b1, 3'd3, 1'b1, 32'h0, 32'h200, '0, '0);
        access(1'b1, 3'd3, 1'b1, '1, '1, '0, '0);
        // R4: machine pending write cannot touch machine bits
        access(1'b1, 3'd1, 1'b0, '1, '1, '0, '0);
        // R5: claimed bit 9 follows hardware, software clear ignored
        access(1'b1, 3'd1, 1'b0, 32'h0, 32'h200, 32'h200, 32'h200);
        access(1'b1, 3'd4, 1'b1, 32'h2, 32'h2, 32'h0, 32'h004);
        // R8: supervisor pending, virtualized write of bit 2 via data bit 1
        access(1'b1, 3'd4, 1'b1, 32'h0, 32'h2, 32'h0, 32'h0);
        access(1'b1, 3'd4, 1'b0, '1, '1, 32'h0, 32'h0);
        // R9: hypervisor views
        access(1'b1, 3'd6, 1'b0, 32'h0, '1, 32'h0, 32'h0);
        access(1'b1, 3'd5, 1'b0, 32'h0, '1, 32'h0, 32'h0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] mk, cl;
            mk = ($urandom % 3 == 0) ? $urandom : ($urandom & 32'hFFF);
            cl = ($urandom % 2 == 0) ? 32'h0 : ($urandom & 32'hEEE);
            access(($urandom % 8) != 0, 3'($urandom % 8), 1'($urandom % 2),
                   $urandom, mk, $urandom, cl);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule